// File: doc/BRIEF.md
# UART Command and Interrupt Controller

This block is the register-side control core of a memory-mapped serial port. Software drives it through a small 32-bit register port. A shared command register carries a 4-bit opcode that turns into one-cycle action pulses, plus enable and disable bits for the receiver and transmitter. The block holds the interrupt mask. It combines the raw event sources with that mask into a masked status and one active-high, level-sensitive interrupt line. It also assembles the status word that software polls.

The shifters, FIFOs and baud generator sit outside. They appear here only as live flags and one-cycle event pulses, and they take the action pulses and enables this block produces. Several offsets serve two purposes: one register on read and a different one on write. The CTS input is asynchronous and passes through a synchronizer inside the block.

Top module: `uctl_core`

## Requirements
- R1: After reset, rx_en_o, tx_en_o, break_o, rfr_o, every action pulse, irq_o, the interrupt mask, clk_sel_o and all sticky flags are 0.
- R2: A write to offset 0x10 takes its opcode from bits [7:4]. Opcode 1 pulses rst_rx_o, 2 pulses rst_tx_o, 3 pulses clr_err_o, 4 pulses clr_brk_o and 7 pulses clr_cts_o. Each pulse is high for exactly the one cycle after the write edge. Every other opcode produces no pulse.
- R3: In a command write, bit 0 sets rx_en_o, bit 1 clears it, bit 2 sets tx_en_o and bit 3 clears it. A disable bit wins over its enable bit. Opcode 1 also clears rx_en_o, and opcode 2 also clears tx_en_o.
- R4: Opcode 5 sets break_o. Opcode 6 or opcode 2 clears it. Other opcodes leave it unchanged.
- R5: Opcode 13 sets rfr_o and opcode 14 clears it. The value holds across all other commands.
- R6: A read of offset 0x08 returns the status word with bits 31:8 at zero. Bit 0 is rx_ready_i, bit 1 rx_full_i, bit 2 tx_ready_i, bit 3 tx_empty_i, bit 4 the overrun flag, bit 5 the parity/framing flag, bit 6 the break flag and bit 7 hunt_i.
- R7: The overrun flag (status bit 4) and the parity/framing flag (status bit 5) are set by overrun_evt_i and frame_err_evt_i. They are cleared only by opcode 3. A set in the same cycle as the clear wins.
- R8: The break flag (status bit 6) is set by break_evt_i and cleared only by opcode 4.
- R9: cts_i passes through two flip-flops. Raw interrupt bit 6 shows the synchronized level two edges after a change. Raw bit 5 is set one edge later on either edge of the synchronized level, and only opcode 7 clears it.
- R10: A read of offset 0x14 returns the raw sources. Bit 0 is tx_lev_i, bit 3 rx_stale_i, bit 4 rx_lev_i, and bits 5 and 6 are as in R9. All other bits read 0.
- R11: A write to offset 0x14 loads the mask, keeping only bits 0, 3, 4, 5 and 6. A read of offset 0x10 returns the raw sources ANDed with the mask.
- R12: irq_o is the OR of the masked status. It follows the mask from the edge that writes the mask, so writing zero removes the interrupt at once.
- R13: A write to 0x0C raises tx_push_o in that cycle, with tx_data_o set to wdata[7:0]. A read of 0x0C raises rx_pop_o and returns rx_data_i zero-extended. A write to 0x08 loads clk_sel_o from wdata[7:0]. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 6 | Byte offset of the access |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational) |
| rx_data_i | input | 8 | Head of the receive FIFO |
| rx_ready_i | input | 1 | Receive data available |
| rx_full_i | input | 1 | Receive FIFO full |
| tx_ready_i | input | 1 | Transmit FIFO has room |
| tx_empty_i | input | 1 | Transmitter fully idle |
| hunt_i | input | 1 | Hunt character seen |
| overrun_evt_i | input | 1 | Overrun event pulse |
| frame_err_evt_i | input | 1 | Parity or framing error pulse |
| break_evt_i | input | 1 | Break detected pulse |
| cts_i | input | 1 | Asynchronous clear-to-send |
| tx_lev_i | input | 1 | Transmit level source |
| rx_stale_i | input | 1 | Receive stale source |
| rx_lev_i | input | 1 | Receive level source |
| tx_push_o | output | 1 | Push tx_data_o into the transmit FIFO |
| tx_data_o | output | 8 | Byte to transmit |
| rx_pop_o | output | 1 | Pop the receive FIFO |
| clk_sel_o | output | 8 | Clock select value |
| rx_en_o | output | 1 | Receiver enable |
| tx_en_o | output | 1 | Transmitter enable |
| break_o | output | 1 | Force break on the line |
| rfr_o | output | 1 | Ready-to-receive asserted |
| rst_rx_o | output | 1 | Receiver reset pulse |
| rst_tx_o | output | 1 | Transmitter reset pulse |
| clr_err_o | output | 1 | Error clear pulse |
| clr_brk_o | output | 1 | Break-interrupt clear pulse |
| clr_cts_o | output | 1 | CTS-change clear pulse |
| irq_o | output | 1 | Level-high interrupt |

## Verification
The bench walks every opcode and every low-nibble pattern of the command register. A decoder that reads the wrong nibble, or that lets a reset opcode leave an enable standing, would show up as a stray or missing pulse or as a stuck enable. It sweeps every mask value against every pattern of the level sources, with the CTS bits both idle and active. A mask that kept reserved bits, or an interrupt that lagged the mask write by a cycle, would show up there. It also sets each sticky flag in the same cycle as its clear and fires the wrong clear opcode at each flag. A design that gave the clear priority would lose an event, and one with crossed clear decodes would drop the wrong flag. The CTS level and change bits are sampled one edge before and at the edge where they are due, which exposes a synchronizer that is too short or too long.

// File: rtl/uctl_pkg.sv
package uctl_pkg;

    // command opcodes, field [7:4] of a command write
    localparam logic [3:0] OP_NOP     = 4'd0;
    localparam logic [3:0] OP_RST_RX  = 4'd1;
    localparam logic [3:0] OP_RST_TX  = 4'd2;
    localparam logic [3:0] OP_CLR_ERR = 4'd3;
    localparam logic [3:0] OP_CLR_BRK = 4'd4;
    localparam logic [3:0] OP_BRK_ON  = 4'd5;
    localparam logic [3:0] OP_BRK_OFF = 4'd6;
    localparam logic [3:0] OP_CLR_CTS = 4'd7;
    localparam logic [3:0] OP_RFR_ON  = 4'd13;
    localparam logic [3:0] OP_RFR_OFF = 4'd14;

    // enable / disable bits in the low nibble of a command write
    localparam int EN_RX_BIT  = 0;
    localparam int DIS_RX_BIT = 1;
    localparam int EN_TX_BIT  = 2;
    localparam int DIS_TX_BIT = 3;

    // interrupt source positions
    localparam int IRQ_W      = 7;
    localparam int IRQ_TXLEV  = 0;
    localparam int IRQ_STALE  = 3;
    localparam int IRQ_RXLEV  = 4;
    localparam int IRQ_CTSCHG = 5;
    localparam int IRQ_CTSNOW = 6;
    localparam logic [IRQ_W-1:0] IRQ_VALID =
        IRQ_W'((1 << IRQ_TXLEV) | (1 << IRQ_STALE) | (1 << IRQ_RXLEV) |
               (1 << IRQ_CTSCHG) | (1 << IRQ_CTSNOW));

    localparam int STAT_W = 8;

    typedef struct packed {
        logic rst_rx;
        logic rst_tx;
        logic clr_err;
        logic clr_brk;
        logic clr_cts;
    } act_t;

endpackage

// File: rtl/uctl_cmd.sv
module uctl_cmd
    import uctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr,
    input  logic [7:0] cmd_byte,
    output act_t       strobe,
    output act_t       act_q,
    output logic       rx_en,
    output logic       tx_en,
    output logic       brk_on,
    output logic       rfr
);

    typedef struct packed {
        logic rx_en;
        logic tx_en;
        logic brk;
        logic rfr;
        act_t act;
    } cmd_state_t;

    cmd_state_t cur_q, nxt_d;
    logic [3:0] op;

    always_comb begin
        op     = cmd_byte[7:4];
        strobe = '0;
        if (cmd_wr) begin
            case (op)
                OP_RST_RX:  strobe.rst_rx  = 1'b1;
                OP_RST_TX:  strobe.rst_tx  = 1'b1;
                OP_CLR_ERR: strobe.clr_err = 1'b1;
                OP_CLR_BRK: strobe.clr_brk = 1'b1;
                OP_CLR_CTS: strobe.clr_cts = 1'b1;
                default:    ;
            endcase
        end

        nxt_d     = cur_q;
        nxt_d.act = strobe;
        if (cmd_wr) begin
            if (cmd_byte[EN_RX_BIT])  nxt_d.rx_en = 1'b1;
            if (cmd_byte[DIS_RX_BIT]) nxt_d.rx_en = 1'b0;
            if (strobe.rst_rx)        nxt_d.rx_en = 1'b0;
            if (cmd_byte[EN_TX_BIT])  nxt_d.tx_en = 1'b1;
            if (cmd_byte[DIS_TX_BIT]) nxt_d.tx_en = 1'b0;
            if (strobe.rst_tx)        nxt_d.tx_en = 1'b0;
            if (op == OP_BRK_ON)                      nxt_d.brk = 1'b1;
            if (op == OP_BRK_OFF || strobe.rst_tx)    nxt_d.brk = 1'b0;
            if (op == OP_RFR_ON)                      nxt_d.rfr = 1'b1;
            if (op == OP_RFR_OFF)                     nxt_d.rfr = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign act_q  = cur_q.act;
    assign rx_en  = cur_q.rx_en;
    assign tx_en  = cur_q.tx_en;
    assign brk_on = cur_q.brk;
    assign rfr    = cur_q.rfr;

    assert_rstrx_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
        act_q.rst_rx |-> $past(cmd_wr && cmd_byte[7:4] == OP_RST_RX));

    assert_rxen_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        act_q.rst_rx |-> !rx_en);

    assert_brk_off_txrst_R4: assert property (@(posedge clk) disable iff (!rst_n)
        act_q.rst_tx |-> !brk_on);

    assert_rfr_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rfr) |-> $past(cmd_wr && cmd_byte[7:4] == OP_RFR_ON));

endmodule

// File: rtl/uctl_sticky.sv
module uctl_sticky
    import uctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ovr_evt,
    input  logic err_evt,
    input  logic brk_evt,
    input  logic cts_in,
    input  logic clr_err,
    input  logic clr_brk,
    input  logic clr_cts,
    output logic ovr,
    output logic err,
    output logic brk,
    output logic cts_now,
    output logic cts_chg
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   cts_prev;
        logic                   ovr;
        logic                   err;
        logic                   brk;
        logic                   chg;
    } flag_state_t;

    flag_state_t cur_q, nxt_d;
    logic [SYNC_STAGES-1:0] shift_in;

    generate
        if (SYNC_STAGES == 1) begin : g_sync_one
            assign shift_in = cts_in;
        end else begin : g_sync_chain
            assign shift_in = {cur_q.sync[SYNC_STAGES-2:0], cts_in};
        end
    endgenerate

    assign cts_now = cur_q.sync[SYNC_STAGES-1];

    always_comb begin
        nxt_d          = cur_q;
        nxt_d.sync     = shift_in;
        nxt_d.cts_prev = cts_now;
        // clear first, then set: a coincident event survives
        if (clr_err) begin
            nxt_d.ovr = 1'b0;
            nxt_d.err = 1'b0;
        end
        if (clr_brk) nxt_d.brk = 1'b0;
        if (clr_cts) nxt_d.chg = 1'b0;
        if (ovr_evt) nxt_d.ovr = 1'b1;
        if (err_evt) nxt_d.err = 1'b1;
        if (brk_evt) nxt_d.brk = 1'b1;
        if (cts_now ^ cur_q.cts_prev) nxt_d.chg = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign ovr     = cur_q.ovr;
    assign err     = cur_q.err;
    assign brk     = cur_q.brk;
    assign cts_chg = cur_q.chg;

    assert_ovr_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovr) |-> $past(clr_err));

    assert_ovr_event_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_evt |=> ovr);

    assert_brk_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(brk) |-> $past(clr_brk));

    assert_ctschg_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cts_chg) |-> $past(clr_cts));

endmodule

// File: rtl/uctl_irq.sv
module uctl_irq
    import uctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mask_wr,
    input  logic [IRQ_W-1:0] mask_in,
    input  logic [IRQ_W-1:0] raw,
    output logic [IRQ_W-1:0] masked,
    output logic             irq
);

    typedef struct packed {
        logic [IRQ_W-1:0] mask;
    } irq_state_t;

    irq_state_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (mask_wr) nxt_d.mask = mask_in & IRQ_VALID;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign masked = raw & cur_q.mask;
    assign irq    = |masked;

    assert_irq_needs_mask_R12: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cur_q.mask != '0));

    assert_mask_zero_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr && (mask_in & IRQ_VALID) == '0) |=> !irq);

endmodule

// File: rtl/uctl_core.sv
module uctl_core
    import uctl_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 32,
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [BYTE_W-1:0] rx_data_i,
    input  logic              rx_ready_i,
    input  logic              rx_full_i,
    input  logic              tx_ready_i,
    input  logic              tx_empty_i,
    input  logic              hunt_i,
    input  logic              overrun_evt_i,
    input  logic              frame_err_evt_i,
    input  logic              break_evt_i,
    input  logic              cts_i,
    input  logic              tx_lev_i,
    input  logic              rx_stale_i,
    input  logic              rx_lev_i,
    output logic              tx_push_o,
    output logic [BYTE_W-1:0] tx_data_o,
    output logic              rx_pop_o,
    output logic [BYTE_W-1:0] clk_sel_o,
    output logic              rx_en_o,
    output logic              tx_en_o,
    output logic              break_o,
    output logic              rfr_o,
    output logic              rst_rx_o,
    output logic              rst_tx_o,
    output logic              clr_err_o,
    output logic              clr_brk_o,
    output logic              clr_cts_o,
    output logic              irq_o
);

    localparam logic [ADDR_W-1:0] OFS_STAT_CLK = ADDR_W'(8'h08);
    localparam logic [ADDR_W-1:0] OFS_FIFO     = ADDR_W'(8'h0C);
    localparam logic [ADDR_W-1:0] OFS_MISR_CMD = ADDR_W'(8'h10);
    localparam logic [ADDR_W-1:0] OFS_RAW_MASK = ADDR_W'(8'h14);

    typedef struct packed {
        logic [BYTE_W-1:0] clk_sel;
    } core_state_t;

    core_state_t cur_q, nxt_d;

    logic             wr_cmd, wr_mask, wr_clk;
    act_t             strobe, act_q;
    logic             ovr, err, brk, cts_now, cts_chg;
    logic [IRQ_W-1:0] raw, masked;
    logic [STAT_W-1:0] status;
    logic             unused_wdata;

    assign unused_wdata = ^reg_wdata[DATA_W-1:BYTE_W];

    assign wr_cmd  = reg_wr && (reg_addr == OFS_MISR_CMD);
    assign wr_mask = reg_wr && (reg_addr == OFS_RAW_MASK);
    assign wr_clk  = reg_wr && (reg_addr == OFS_STAT_CLK);

    uctl_cmd u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (wr_cmd),
        .cmd_byte (reg_wdata[7:0]),
        .strobe   (strobe),
        .act_q    (act_q),
        .rx_en    (rx_en_o),
        .tx_en    (tx_en_o),
        .brk_on   (break_o),
        .rfr      (rfr_o)
    );

    uctl_sticky #(.SYNC_STAGES(SYNC_STAGES)) u_sticky (
        .clk     (clk),
        .rst_n   (rst_n),
        .ovr_evt (overrun_evt_i),
        .err_evt (frame_err_evt_i),
        .brk_evt (break_evt_i),
        .cts_in  (cts_i),
        .clr_err (strobe.clr_err),
        .clr_brk (strobe.clr_brk),
        .clr_cts (strobe.clr_cts),
        .ovr     (ovr),
        .err     (err),
        .brk     (brk),
        .cts_now (cts_now),
        .cts_chg (cts_chg)
    );

    always_comb begin
        raw             = '0;
        raw[IRQ_TXLEV]  = tx_lev_i;
        raw[IRQ_STALE]  = rx_stale_i;
        raw[IRQ_RXLEV]  = rx_lev_i;
        raw[IRQ_CTSCHG] = cts_chg;
        raw[IRQ_CTSNOW] = cts_now;
    end

    uctl_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .mask_wr (wr_mask),
        .mask_in (reg_wdata[IRQ_W-1:0]),
        .raw     (raw),
        .masked  (masked),
        .irq     (irq_o)
    );

    assign status = {hunt_i, brk, err, ovr, tx_empty_i, tx_ready_i, rx_full_i, rx_ready_i};

    always_comb begin
        nxt_d = cur_q;
        if (wr_clk) nxt_d.clk_sel = reg_wdata[BYTE_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    always_comb begin
        case (reg_addr)
            OFS_STAT_CLK: reg_rdata = DATA_W'(status);
            OFS_FIFO:     reg_rdata = DATA_W'(rx_data_i);
            OFS_MISR_CMD: reg_rdata = DATA_W'(masked);
            OFS_RAW_MASK: reg_rdata = DATA_W'(raw);
            default:      reg_rdata = '0;
        endcase
    end

    assign clk_sel_o = cur_q.clk_sel;
    assign tx_push_o = reg_wr && (reg_addr == OFS_FIFO);
    assign tx_data_o = reg_wdata[BYTE_W-1:0];
    assign rx_pop_o  = reg_rd && (reg_addr == OFS_FIFO);
    assign rst_rx_o  = act_q.rst_rx;
    assign rst_tx_o  = act_q.rst_tx;
    assign clr_err_o = act_q.clr_err;
    assign clr_brk_o = act_q.clr_brk;
    assign clr_cts_o = act_q.clr_cts;

    assert_clk_sel_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_clk) |-> $stable(clk_sel_o));

endmodule

// File: tb/tb_uctl_core.sv
module tb_uctl_core;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [5:0]  reg_addr;
    logic        reg_wr, reg_rd;
    logic [31:0] reg_wdata, reg_rdata;
    logic [7:0]  rx_data_i;
    logic        rx_ready_i, rx_full_i, tx_ready_i, tx_empty_i, hunt_i;
    logic        overrun_evt_i, frame_err_evt_i, break_evt_i, cts_i;
    logic        tx_lev_i, rx_stale_i, rx_lev_i;
    logic        tx_push_o, rx_pop_o;
    logic [7:0]  tx_data_o, clk_sel_o;
    logic        rx_en_o, tx_en_o, break_o, rfr_o;
    logic        rst_rx_o, rst_tx_o, clr_err_o, clr_brk_o, clr_cts_o, irq_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    uctl_core dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_data_i(rx_data_i), .rx_ready_i(rx_ready_i), .rx_full_i(rx_full_i),
        .tx_ready_i(tx_ready_i), .tx_empty_i(tx_empty_i), .hunt_i(hunt_i),
        .overrun_evt_i(overrun_evt_i), .frame_err_evt_i(frame_err_evt_i),
        .break_evt_i(break_evt_i), .cts_i(cts_i), .tx_lev_i(tx_lev_i),
        .rx_stale_i(rx_stale_i), .rx_lev_i(rx_lev_i), .tx_push_o(tx_push_o),
        .tx_data_o(tx_data_o), .rx_pop_o(rx_pop_o), .clk_sel_o(clk_sel_o),
        .rx_en_o(rx_en_o), .tx_en_o(tx_en_o), .break_o(break_o), .rfr_o(rfr_o),
        .rst_rx_o(rst_rx_o), .rst_tx_o(rst_tx_o), .clr_err_o(clr_err_o),
        .clr_brk_o(clr_brk_o), .clr_cts_o(clr_cts_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a negedge; returns at the negedge after the write edge
    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr    = 1'b0;
        reg_addr  = 6'h00;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [4:0] pulses();
        return {rst_rx_o, rst_tx_o, clr_err_o, clr_brk_o, clr_cts_o};
    endfunction

    logic [31:0] v;
    logic        m_brk, m_rfr, m_rx, m_tx;
    logic [4:0]  exp_p;
    logic [6:0]  exp_raw;

    initial begin
        rst_n = 1'b0; reg_addr = '0; reg_wr = 0; reg_rd = 0; reg_wdata = '0;
        rx_data_i = '0; rx_ready_i = 0; rx_full_i = 0; tx_ready_i = 0; tx_empty_i = 0;
        hunt_i = 0; overrun_evt_i = 0; frame_err_evt_i = 0; break_evt_i = 0; cts_i = 0;
        tx_lev_i = 0; rx_stale_i = 0; rx_lev_i = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 enables", {28'b0, rx_en_o, tx_en_o, break_o, rfr_o}, 32'h0);
        chk("R1 pulses", {27'b0, pulses()}, 32'h0);
        chk("R1 clk_sel", {24'b0, clk_sel_o}, 32'h0);
        rd(6'h08, v); chk("R1 status", v, 32'h0);
        tx_lev_i = 1; rx_stale_i = 1; rx_lev_i = 1; #1;
        chk("R1 irq masked off", {31'b0, irq_o}, 32'h0);
        rd(6'h10, v); chk("R1 misr", v, 32'h0);
        tx_lev_i = 0; rx_stale_i = 0; rx_lev_i = 0;

        // R6 live status bits
        for (int s = 0; s < 32; s++) begin
            {hunt_i, tx_empty_i, tx_ready_i, rx_full_i, rx_ready_i} = 5'(s);
            rd(6'h08, v);
            chk("R6 status", v, {24'b0, hunt_i, 3'b000, tx_empty_i, tx_ready_i, rx_full_i, rx_ready_i});
        end
        {hunt_i, tx_empty_i, tx_ready_i, rx_full_i, rx_ready_i} = 5'b0;

        // R2 R4 R5 opcode sweep
        m_brk = 0; m_rfr = 0;
        for (int op = 0; op < 16; op++) begin
            wr(6'h10, {24'b0, 4'(op), 4'b0});
            exp_p = {op == 1, op == 2, op == 3, op == 4, op == 7};
            if (op == 5) m_brk = 1;
            if (op == 6 || op == 2) m_brk = 0;
            if (op == 13) m_rfr = 1;
            if (op == 14) m_rfr = 0;
            chk("R2 pulse", {27'b0, pulses()}, {27'b0, exp_p});
            chk("R4 break", {31'b0, break_o}, {31'b0, m_brk});
            chk("R5 rfr", {31'b0, rfr_o}, {31'b0, m_rfr});
            @(negedge clk);
            chk("R2 one cycle", {27'b0, pulses()}, 32'h0);
        end
        wr(6'h10, 32'h50); chk("R4 set", {31'b0, break_o}, 32'h1);
        wr(6'h10, 32'h30); chk("R4 other op keeps", {31'b0, break_o}, 32'h1);
        wr(6'h10, 32'h20); chk("R4 tx reset clears", {31'b0, break_o}, 32'h0);
        wr(6'h10, 32'hD0); wr(6'h10, 32'h10);
        chk("R5 holds", {31'b0, rfr_o}, 32'h1);
        wr(6'h14, 32'h79); chk("R2 mask write no pulse", {27'b0, pulses()}, 32'h0);
        wr(6'h14, 32'h00);

        // R3 enable bits
        wr(6'h10, 32'h00); m_rx = 0; m_tx = 0;
        for (int n = 0; n < 16; n++) begin
            wr(6'h10, {28'b0, 4'(n)});
            m_rx = (m_rx | n[0]) & ~n[1];
            m_tx = (m_tx | n[2]) & ~n[3];
            chk("R3 enables", {30'b0, rx_en_o, tx_en_o}, {30'b0, m_rx, m_tx});
        end
        wr(6'h10, 32'h05);
        chk("R3 0x05 both on", {30'b0, rx_en_o, tx_en_o}, 32'h3);
        wr(6'h10, 32'h10);
        chk("R3 rx reset", {30'b0, rx_en_o, tx_en_o}, 32'h1);
        wr(6'h10, 32'h21);
        chk("R3 tx reset", {30'b0, rx_en_o, tx_en_o}, 32'h2);

        // R7 overrun and framing sticky
        overrun_evt_i = 1; @(negedge clk); overrun_evt_i = 0;
        idle(2); rd(6'h08, v); chk("R7 overrun set", v & 32'h70, 32'h10);
        wr(6'h10, 32'h40); rd(6'h08, v); chk("R7 op4 keeps overrun", v & 32'h70, 32'h10);
        wr(6'h10, 32'h70); rd(6'h08, v); chk("R7 op7 keeps overrun", v & 32'h70, 32'h10);
        wr(6'h10, 32'h30); rd(6'h08, v); chk("R7 op3 clears", v & 32'h70, 32'h00);
        frame_err_evt_i = 1; @(negedge clk); frame_err_evt_i = 0;
        rd(6'h08, v); chk("R7 frame set", v & 32'h70, 32'h20);
        overrun_evt_i = 1; wr(6'h10, 32'h30); overrun_evt_i = 0;
        rd(6'h08, v); chk("R7 set wins over clear", v & 32'h70, 32'h10);
        wr(6'h10, 32'h30); rd(6'h08, v); chk("R7 cleared", v & 32'h70, 32'h00);

        // R8 break flag
        break_evt_i = 1; @(negedge clk); break_evt_i = 0;
        rd(6'h08, v); chk("R8 break set", v & 32'h70, 32'h40);
        wr(6'h10, 32'h30); rd(6'h08, v); chk("R8 op3 keeps", v & 32'h70, 32'h40);
        wr(6'h10, 32'h40); rd(6'h08, v); chk("R8 op4 clears", v & 32'h70, 32'h00);

        // R9 CTS synchronizer and change flag
        cts_i = 1;
        @(negedge clk); rd(6'h14, v); chk("R9 not yet synced", v & 32'h60, 32'h00);
        @(negedge clk); rd(6'h14, v); chk("R9 level after two edges", v & 32'h60, 32'h40);
        @(negedge clk); rd(6'h14, v); chk("R9 change after three", v & 32'h60, 32'h60);
        wr(6'h10, 32'h30); rd(6'h14, v); chk("R9 op3 keeps change", v & 32'h60, 32'h60);
        wr(6'h10, 32'h70); rd(6'h14, v); chk("R9 op7 clears change", v & 32'h60, 32'h40);
        cts_i = 0; idle(3); rd(6'h14, v); chk("R9 falling edge", v & 32'h60, 32'h20);
        wr(6'h10, 32'h70); rd(6'h14, v); chk("R9 cleared", v & 32'h60, 32'h00);

        // R10 R11 R12 mask / raw sweep, CTS idle then active
        for (int phase = 0; phase < 2; phase++) begin
            if (phase == 1) begin cts_i = 1; idle(4); end
            for (int m = 0; m < 128; m++) begin
                wr(6'h14, {25'b0, 7'(m)});
                for (int s = 0; s < 8; s++) begin
                    {rx_lev_i, rx_stale_i, tx_lev_i} = 3'(s);
                    exp_raw = {phase[0], phase[0], rx_lev_i, rx_stale_i, 2'b00, tx_lev_i};
                    rd(6'h14, v); chk("R10 raw", v, {25'b0, exp_raw});
                    rd(6'h10, v); chk("R11 masked", v, {25'b0, exp_raw & 7'(m) & 7'h79});
                    chk("R12 irq", {31'b0, irq_o}, {31'b0, |(exp_raw & 7'(m) & 7'h79)});
                end
            end
        end
        {rx_lev_i, rx_stale_i, tx_lev_i} = 3'b111;
        wr(6'h14, 32'h7F); chk("R12 irq on", {31'b0, irq_o}, 32'h1);
        reg_addr = 6'h14; reg_wdata = 32'h0; reg_wr = 1;
        @(posedge clk); #1;
        chk("R12 drops at mask edge", {31'b0, irq_o}, 32'h0);
        @(negedge clk); reg_wr = 0;

        // R13 data path, clock select, unmapped
        reg_addr = 6'h0C; reg_wdata = 32'hFFFF_FFA5; reg_wr = 1; #1;
        chk("R13 tx push", {23'b0, tx_push_o, tx_data_o}, {23'b0, 1'b1, 8'hA5});
        @(posedge clk); @(negedge clk); reg_wr = 0; #1;
        chk("R13 push ends", {31'b0, tx_push_o}, 32'h0);
        rx_data_i = 8'h3C; reg_rd = 1; rd(6'h0C, v);
        chk("R13 rx data", v, 32'h3C);
        chk("R13 rx pop", {31'b0, rx_pop_o}, 32'h1);
        reg_rd = 0; #1; chk("R13 pop ends", {31'b0, rx_pop_o}, 32'h0);
        wr(6'h08, 32'h5A); chk("R13 clk_sel", {24'b0, clk_sel_o}, 32'h5A);
        wr(6'h10, 32'h00); chk("R13 clk_sel kept", {24'b0, clk_sel_o}, 32'h5A);
        rd(6'h04, v); chk("R13 unmapped", v, 32'h0);
        rd(6'h00, v); chk("R13 unmapped zero", v, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule